// File: doc/BRIEF.md
# Three-Phase Double-Buffered Motor Output Stage

This block drives the six gate outputs of a three-phase bridge: U, U-bar, V, V-bar, W and W-bar. Software stages two 6-bit output patterns in a pair of buffer registers over a small register bus. A transfer strobe copies both patterns into an internal shift register. The first pattern drives the outputs straight away. The second pattern takes over on the next falling edge of an external one-shot pulse. This lets one timer period produce two consecutive bridge states without software stepping in between.

Each complementary pair goes through its own dead-time counter. When an output moves from inactive to active, the move waits a programmed number of count-source ticks. When an output moves from active to inactive, the move happens at once. This prevents shoot-through. A pattern that would turn on both switches of one leg is replaced by both-off. A bypass input removes the delay. A select input chooses which of two clock-enable strobes the counters count. Reads of either buffer address return the live shift-register pattern, so software sees what the bridge is actually being driven with.

Top module: `tri_phase_out`

## Requirements
- R1: A pattern bit of 0 means active and 1 means inactive. Pattern bit 0 is U, bit 1 U-bar, bit 2 V, bit 3 V-bar, bit 4 W and bit 5 W-bar, and `phase_out` uses the same bit positions. Register address 0 is the first buffer, address 1 the second buffer and address 2 the dead-time count.
- R2: After reset, both buffers hold 0x00, the shift register and `phase_out` hold 0x3F (all inactive), and the dead-time count is 1.
- R3: A cycle with `xfer_trig` high copies both buffers into the shift register. Counting the clock edge that samples the strobe as the first edge, the first pattern appears on readback at the second edge. With bypass on, the first pattern also appears on `phase_out` at the second edge.
- R4: If `oneshot_in` is sampled high on one edge and low on the next, that later edge loads the stored second pattern. When a transfer strobe and a falling edge land on the same edge, the transfer wins.
- R5: Buffer writes made after a transfer do not change the shift register until the next transfer.
- R6: A read of address 0 or 1 returns {2'b00, shift register}, one cycle after the address is presented. Written bits 7:6 of a buffer are dropped. Addresses 2 and 3 read as 0.
- R7: If a pattern sets both bits of a pair to 0 (both active), both outputs of that pair are driven to 1 (inactive).
- R8: An output going from active to inactive changes one cycle after the shift register changes, whether bypass is on or off.
- R9: With bypass off and a tick on every cycle, an output going from inactive to active changes n cycles later than an inactive-going change caused by the same pattern, where n is the dead-time count. A count of 0 behaves as 1.
- R10: With `dt_bypass` high, inactive-to-active changes take effect with no delay, on the same edge as inactive-going changes.
- R11: `dt_src_sel` = 0 makes the counters count `tick_a`, and 1 makes them count `tick_b`. The unselected strobe has no effect.
- R12: A new pattern that asks for an inactive-to-active change on a pair while that pair's counter is running reloads the counter with the full count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 first buffer, 1 second buffer, 2 dead-time count) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Registered read data |
| xfer_trig | input | 1 | Transfer strobe that loads both patterns |
| oneshot_in | input | 1 | One-shot pulse; its falling edge applies the second pattern |
| tick_a | input | 1 | Dead-time count enable, source 0 |
| tick_b | input | 1 | Dead-time count enable, source 1 |
| dt_src_sel | input | 1 | Selects tick_b when high, tick_a when low |
| dt_bypass | input | 1 | Removes the dead-time delay |
| phase_out | output | 6 | Registered bridge outputs, 0 = active |

## Verification
The shift register can be seen on readback one edge after it changes. So a pattern loaded from the wrong buffer, or loaded on the wrong edge, shows up as a wrong `rd_data` value within two cycles of the strobe or the falling edge. A dead-time counter that is loaded, reloaded or decremented wrongly shows at `phase_out` as an active edge that comes one or more cycles early or late compared with the programmed count, or that never comes. A wrong pair-exclusion or inactive-path state shows on the very next edge as an output that stays active when it should be off.

// File: rtl/tpo_pkg.sv
package tpo_pkg;
  localparam int PAIRS = 3;
  localparam int PW    = 2 * PAIRS;

  typedef enum logic [1:0] {
    ADDR_PAT0 = 2'd0,
    ADDR_PAT1 = 2'd1,
    ADDR_DEAD = 2'd2
  } reg_addr_e;

  // A leg with both switches requested on is turned fully off (R7)
  function automatic logic [1:0] safe_pair(input logic [1:0] p);
    return (p == 2'b00) ? 2'b11 : p;
  endfunction
endpackage

// File: rtl/tpo_regs.sv
module tpo_regs
  import tpo_pkg::*;
#(
  parameter int DW   = 8,
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [1:0]      rd_addr,
  input  logic [PW-1:0]   cur,
  output logic [PW-1:0]   pat0,
  output logic [PW-1:0]   pat1,
  output logic [DT_W-1:0] dt_n,
  output logic [DW-1:0]   rd_data
);
  localparam logic [DT_W-1:0] DT_RST = DT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pat0    <= '0;
      pat1    <= '0;
      dt_n    <= DT_RST;   // R2
      rd_data <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          ADDR_PAT0: pat0 <= wr_data[PW-1:0];   // R6: upper bits dropped
          ADDR_PAT1: pat1 <= wr_data[PW-1:0];
          ADDR_DEAD: dt_n <= wr_data[DT_W-1:0];
          default:   ;
        endcase
      end
      if (rd_addr == ADDR_PAT0 || rd_addr == ADDR_PAT1)
        rd_data <= {{(DW-PW){1'b0}}, cur};
      else
        rd_data <= '0;
    end
  end

  // R6
  rd_pad_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data[DW-1:PW] == '0);
endmodule

// File: rtl/tpo_shift.sv
module tpo_shift
  import tpo_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          xfer,
  input  logic          oneshot,
  input  logic [PW-1:0] pat0,
  input  logic [PW-1:0] pat1,
  output logic [PW-1:0] cur
);
  logic [PW-1:0] nxt;
  logic          os_q;
  logic          os_fall;

  assign os_fall = os_q & ~oneshot;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur  <= '1;
      nxt  <= '1;
      os_q <= 1'b0;
    end else begin
      os_q <= oneshot;
      if (xfer) begin
        cur <= pat0;
        nxt <= pat1;
      end else if (os_fall) begin
        cur <= nxt;
      end
    end
  end

  // R3
  xfer_load_chk: assert property (@(posedge clk) disable iff (rst)
    xfer |=> cur == $past(pat0));
  // R4
  fall_load_chk: assert property (@(posedge clk) disable iff (rst)
    (os_fall && !xfer) |=> cur == $past(nxt));
endmodule

// File: rtl/tpo_dt_pair.sv
module tpo_dt_pair
  import tpo_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      want,
  input  logic            bypass,
  input  logic            tick,
  input  logic [DT_W-1:0] dt_n,
  output logic [1:0]      pout
);
  localparam logic [DT_W-1:0] CNT_ONE = DT_W'(1);

  logic [1:0]      tgt, tgt_q, rise;
  logic            busy, chg, fire;
  logic [DT_W-1:0] cnt;

  assign tgt  = safe_pair(want);
  assign chg  = (tgt != tgt_q);
  assign rise = ~tgt & pout;
  assign fire = busy & tick & (cnt <= CNT_ONE) & ~chg;   // R9: 0 acts as 1

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q <= 2'b11;
      busy  <= 1'b0;
      cnt   <= '0;
      pout  <= 2'b11;
    end else begin
      tgt_q <= tgt;
      if (chg) begin
        busy <= (|rise) & ~bypass;      // R12: reload on a new request
        cnt  <= dt_n;
      end else if (fire) begin
        busy <= 1'b0;
      end else if (busy && tick) begin
        cnt <= cnt - CNT_ONE;
      end
      for (int i = 0; i < 2; i++) begin
        if (tgt[i])              pout[i] <= 1'b1;   // R8
        else if (bypass || fire) pout[i] <= 1'b0;   // R10, R9
      end
    end
  end

  // R7
  pair_excl_chk: assert property (@(posedge clk) disable iff (rst)
    pout != 2'b00);
  // R9
  dt_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(pout[0]) && !pout[0] && !$past(bypass)) |-> $past(busy));
  // R8
  off_fast_chk: assert property (@(posedge clk) disable iff (rst)
    (tgt == 2'b11) |=> pout == 2'b11);
endmodule

// File: rtl/tri_phase_out.sv
module tri_phase_out
  import tpo_pkg::*;
#(
  parameter int DW   = 8,
  parameter int DT_W = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          xfer_trig,
  input  logic          oneshot_in,
  input  logic          tick_a,
  input  logic          tick_b,
  input  logic          dt_src_sel,
  input  logic          dt_bypass,
  output logic [PW-1:0] phase_out
);
  logic [PW-1:0]   pat0, pat1, cur, pout_all;
  logic [DT_W-1:0] dt_n;
  logic            tick_sel;

  assign tick_sel = dt_src_sel ? tick_b : tick_a;   // R11

  tpo_regs #(.DW(DW), .DT_W(DT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .cur(cur), .pat0(pat0), .pat1(pat1), .dt_n(dt_n),
    .rd_data(rd_data)
  );

  tpo_shift u_shift (
    .clk(clk), .rst(rst), .xfer(xfer_trig), .oneshot(oneshot_in),
    .pat0(pat0), .pat1(pat1), .cur(cur)
  );

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    tpo_dt_pair #(.DT_W(DT_W)) u_pair (
      .clk(clk), .rst(rst), .want(cur[2*p +: 2]), .bypass(dt_bypass),
      .tick(tick_sel), .dt_n(dt_n), .pout(pout_all[2*p +: 2])
    );
  end

  assign phase_out = pout_all;   // R1: same bit order as the patterns
endmodule

// File: tb/sim_tri_phase_out.sv
module sim_tri_phase_out;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, wr_en, xfer_trig, oneshot_in, tick_a, tick_b, dt_src_sel, dt_bypass;
  logic [1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [5:0] phase_out;
  int         checks = 0, errors = 0;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tri_phase_out u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .xfer_trig(xfer_trig),
    .oneshot_in(oneshot_in), .tick_a(tick_a), .tick_b(tick_b),
    .dt_src_sel(dt_src_sel), .dt_bypass(dt_bypass), .phase_out(phase_out)
  );

  function automatic logic [5:0] safe6(input logic [5:0] v);
    logic [5:0] r = v;
    for (int p = 0; p < 3; p++)
      if (v[2*p +: 2] == 2'b00) r[2*p +: 2] = 2'b11;
    return r;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic trig();
    @(negedge clk); xfer_trig = 1'b1;
    @(negedge clk); xfer_trig = 1'b0;
  endtask

  task automatic fall();
    @(negedge clk); oneshot_in = 1'b1;
    @(negedge clk); oneshot_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic dt_case(input logic [7:0] n, input int eff);
    wr(2'd2, n);
    wr(2'd0, 8'h15);
    trig(); step(1);
    chk("R8 inactive edge immediate", {2'b0, phase_out}, 8'h3F);
    step(eff - 1);
    chk("R9 active edge held", {2'b0, phase_out}, 8'h3F);
    step(1);
    chk("R9 active edge after count", {2'b0, phase_out}, 8'h15);
    wr(2'd0, 8'h2A);
    trig(); step(eff);
    chk("R9 reverse held", {2'b0, phase_out}, 8'h3F);
    step(1);
    chk("R9 reverse after count", {2'b0, phase_out}, 8'h2A);
  endtask

  initial begin
    rst = 1'b1; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    xfer_trig = 0; oneshot_in = 0; tick_a = 1; tick_b = 0;
    dt_src_sel = 0; dt_bypass = 0;
    step(4);
    rst = 1'b0;
    step(1);
    chk("R2 reset outputs", {2'b0, phase_out}, 8'h3F);
    chk("R2 reset readback", rd_data, 8'h3F);

    // R2: reset dead-time count is 1; first pattern 0x2A makes U,V,W active
    wr(2'd0, 8'h2A);
    trig(); step(1);
    chk("R2 dead count 1 held", {2'b0, phase_out}, 8'h3F);
    step(1);
    chk("R2 R1 dead count 1 fires", {2'b0, phase_out}, 8'h2A);

    dt_case(8'd3, 3);
    dt_case(8'd0, 1);
    dt_case(8'd10, 10);
    dt_case(8'd255, 255);

    // R11: select tick_b while it is idle
    wr(2'd2, 8'd3);
    dt_src_sel = 1'b1;
    wr(2'd0, 8'h15);
    trig(); step(20);
    chk("R11 unselected tick ignored", {2'b0, phase_out}, 8'h3F);
    tick_b = 1'b1;
    step(2);
    chk("R11 selected tick held", {2'b0, phase_out}, 8'h3F);
    step(1);
    chk("R11 selected tick fires", {2'b0, phase_out}, 8'h15);
    tick_b = 1'b0; dt_src_sel = 1'b0;

    // R12: restart on new request
    wr(2'd2, 8'd10);
    wr(2'd0, 8'h3F);
    trig(); step(1);
    chk("R12 idle", {2'b0, phase_out}, 8'h3F);
    wr(2'd0, 8'h3E);
    trig(); step(5);
    wr(2'd0, 8'h3D);
    trig(); step(3);
    chk("R12 no early fire", {2'b0, phase_out}, 8'h3F);
    step(7);
    chk("R12 restart held", {2'b0, phase_out}, 8'h3F);
    step(1);
    chk("R12 restart fires", {2'b0, phase_out}, 8'h3D);

    // Sweep with bypass: R1 R3 R4 R6 R7 R10
    dt_bypass = 1'b1;
    for (int v = 0; v < 64; v++) begin
      logic [5:0] a, b;
      a = 6'(v); b = ~a;
      wr(2'd0, {2'b11, a});
      wr(2'd1, {2'b10, b});
      trig(); step(1);
      chk("R3 R7 R10 first pattern out", {2'b0, phase_out}, {2'b0, safe6(a)});
      chk("R3 R6 first pattern read", rd_data, {2'b0, a});
      fall(); step(1);
      chk("R4 R7 second pattern out", {2'b0, phase_out}, {2'b0, safe6(b)});
      chk("R4 R6 second pattern read", rd_data, {2'b0, b});
    end

    // R4: transfer beats a coincident falling edge
    wr(2'd0, 8'h15);
    wr(2'd1, 8'h2A);
    @(negedge clk); oneshot_in = 1'b1;
    @(negedge clk); oneshot_in = 1'b0; xfer_trig = 1'b1;
    @(negedge clk); xfer_trig = 1'b0;
    step(1);
    chk("R4 transfer wins", rd_data, 8'h15);

    // R5: buffer writes after a transfer do not leak
    wr(2'd0, 8'h3F);
    wr(2'd1, 8'h00);
    fall(); step(1);
    chk("R5 stale second pattern kept", rd_data, 8'h2A);
    chk("R5 outputs keep second pattern", {2'b0, phase_out}, 8'h2A);
    trig(); step(1);
    chk("R5 new transfer takes writes", rd_data, 8'h3F);

    // R6: read of addresses 1, 2 and 3
    rd_addr = 2'd1; step(1);
    chk("R6 address 1 read", rd_data, 8'h3F);
    rd_addr = 2'd2; step(1);
    chk("R6 address 2 read", rd_data, 8'h00);
    rd_addr = 2'd3; step(1);
    chk("R6 address 3 read", rd_data, 8'h00);
    rd_addr = 2'd0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule